// File: doc/BRIEF.md
# SONET Overhead Serial Drop Port

This block takes overhead bytes that an upstream framer has already pulled from a received SONET frame and sends them out serially to outboard devices. It has five streams. The local orderwire, express orderwire and maintenance bytes each leave on their own data line, and all three share one reference clock that runs at eight periods per frame. The section data communications channel carries three bytes per frame. The line data communications channel carries nine bytes per frame. Each of the two channels has its own serial line and its own gapped reference clock.

All timing comes from one system clock. A frame is a fixed number of system cycles, set by `FRAME_CYC`. Each reference clock has to produce a whole number of periods in that window. The block spreads those periods across the frame with a remainder accumulator, so a single clock's high and low phases may differ by one system cycle, and that is how the gapping appears. Each rising edge of the start-of-frame input restarts every stream and latches a fresh set of bytes. If no frame pulse arrives within one nominal frame, all stream activity stops and the outputs hold their last values. A free-running 8 kHz reference, one frame long, runs independently of the frame pulse.

Top module: `oh_serial_drop`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every serial data line and every reference clock is low, and `ref8k` is high.
- R2: Let k be the cycle offset from the first cycle after a rising edge of `sofIn` is sampled, with k = 0 for that cycle, and let F be `FRAME_CYC`. The event count is `ev(N,k) = floor(2N(k+1)/F)`. `ordClk` equals the low bit of ev(8,k), which gives exactly 8 periods per frame and ends the frame low.
- R3: `e1Ser`, `e2Ser` and `f1Ser` send their latched bytes MSB first. At offset k each line shows bit `7 - min(floor(ev(8,k)/2), 7)`, so the MSB is present from k = 0.
- R4: `sdccClk` equals the low bit of ev(24,k), which gives 24 gapped periods per frame.
- R5: `ldccClk` equals the low bit of ev(72,k), which gives 72 gapped periods per frame.
- R6: The channel data lines send their 24-bit (`sdccBytes`) and 72-bit (`ldccBytes`) words MSB first. The word's bit [W-1] holds the byte's MSB and goes out first. The line shows bit `W-1 - min(floor(ev(W,k)/2), W-1)` and changes only in the cycle where its clock falls.
- R7: Input bytes are captured only in the cycle that samples a rising edge of `sofIn`. A change in the middle of a frame has no effect on any output until the next rising edge.
- R8: A rising edge of `sofIn` restarts every stream at k = 0, even if the previous frame is short. Holding `sofIn` high for many cycles counts as a single edge.
- R9: If no rising edge occurs, the streams stop at offset k = F-1 and stay there. From then on the clocks are low and the data lines hold their final bits until the next edge.
- R10: `ref8k` is high for the first `FRAME_CYC/2` cycles of each `FRAME_CYC`-cycle period, counted from the release of reset, and `sofIn` has no influence on it.
- R11: Before the first rising edge after reset, every clock and data line stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sofIn | input | 1 | Start-of-frame indication; high during the first overhead row |
| e1Byte | input | 8 | Local orderwire byte of the current frame |
| e2Byte | input | 8 | Express orderwire byte of the current frame |
| f1Byte | input | 8 | Maintenance byte of the current frame |
| sdccBytes | input | 24 | Section channel bytes, first byte in [23:16] |
| ldccBytes | input | 72 | Line channel bytes, first byte in [71:64] |
| e1Ser | output | 1 | Serial local orderwire data |
| e2Ser | output | 1 | Serial express orderwire data |
| f1Ser | output | 1 | Serial maintenance data |
| ordClk | output | 1 | Shared orderwire/maintenance reference clock, 8 periods per frame |
| sdccSer | output | 1 | Serial section channel data |
| sdccClk | output | 1 | Gapped section channel clock, 24 periods per frame |
| ldccSer | output | 1 | Serial line channel data |
| ldccClk | output | 1 | Gapped line channel clock, 72 periods per frame |
| ref8k | output | 1 | Free-running frame-rate reference |

## Verification
The serializers are driven with regular frames whose bytes change every frame. This shows whether bits leave MSB first and in the right order across the three data lanes. In some of those frames the bytes also change halfway through the frame, which separates a design that latches once per frame from one that reads its inputs live. A frame pulse that arrives early tests whether the streams realign to the new edge or keep running on the old phase. A pulse held high for longer than a frame, and a run with no pulse at all, test whether level and edge are confused and whether the freeze after one nominal frame works. Every output is compared on every clock with a behavioural model computed from the event-count formula.

// File: rtl/ohd_pkg.sv
package ohd_pkg;
  // Strobes from the frame controller to the serializer datapath
  typedef struct packed {
    logic frameStart;  // rising edge of start-of-frame seen this cycle
    logic advance;     // step every stream by one cycle offset
  } ohdStrb_t;
endpackage

// File: rtl/ohd_ctrl.sv
module ohd_ctrl
  import ohd_pkg::*;
#(
  parameter int FRAME_CYC = 500
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     sofIn,
  output ohdStrb_t strb,
  output logic     ref8k
);
  localparam int KW = $clog2(FRAME_CYC);
  localparam logic [KW-1:0] STOP_PREV = KW'(FRAME_CYC - 2);
  localparam logic [KW-1:0] LAST_K    = KW'(FRAME_CYC - 1);
  localparam logic [KW-1:0] HALF      = KW'(FRAME_CYC / 2);

  logic          sofQ;
  logic          active;
  logic [KW-1:0] kCnt;
  logic [KW-1:0] refCnt;
  logic          sofEdge;

  assign sofEdge = sofIn & ~sofQ;

  always_comb begin
    strb.frameStart = sofEdge;
    strb.advance    = active & ~sofEdge;
  end

  // Frame offset counter: restarts on an edge, stops at the last offset
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sofQ   <= 1'b0;
      active <= 1'b0;
      kCnt   <= '0;
    end else begin
      sofQ <= sofIn;
      if (sofEdge) begin
        kCnt   <= '0;
        active <= 1'b1;
      end else if (active) begin
        kCnt <= kCnt + 1'b1;
        if (kCnt == STOP_PREV) active <= 1'b0;
      end
    end
  end

  // Free-running frame-rate reference
  always_ff @(posedge clk) begin
    if (!rstN) refCnt <= '0;
    else if (refCnt == LAST_K) refCnt <= '0;
    else refCnt <= refCnt + 1'b1;
  end

  assign ref8k = (refCnt < HALF);

  // R9
  kcnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    active |-> (kCnt < LAST_K));
  // R9
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!active && !sofEdge) |=> $stable(kCnt));
  // R8
  single_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.frameStart |=> !strb.frameStart);
  // R10
  ref_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ref8k) |-> (refCnt == '0));
endmodule

// File: rtl/ohd_serial_lane.sv
module ohd_serial_lane
  import ohd_pkg::*;
#(
  parameter int FRAME_CYC = 500,
  parameter int BITS      = 8,
  parameter int LANES     = 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ohdStrb_t              strb,
  input  logic [LANES*BITS-1:0] loadBits,
  output logic                  serClk,
  output logic [LANES-1:0]      serData
);
  localparam int STEP = 2 * BITS;
  localparam int AW   = $clog2(FRAME_CYC + STEP + 1);
  localparam int IW   = $clog2(BITS);
  localparam logic [AW-1:0] STEP_V  = AW'(STEP);
  localparam logic [AW-1:0] FRAME_V = AW'(FRAME_CYC);
  localparam logic [IW-1:0] LAST_I  = IW'(BITS - 1);

  logic [AW-1:0]         acc;
  logic [AW-1:0]         accSum;
  logic                  wrap;
  logic                  clkQ;
  logic [IW-1:0]         bitIdx;
  logic [LANES*BITS-1:0] shadow;

  assign accSum = acc + STEP_V;
  assign wrap   = (accSum >= FRAME_V);

  // Remainder accumulator spreads 2*BITS clock edges over one frame
  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc    <= '0;
      clkQ   <= 1'b0;
      bitIdx <= '0;
      shadow <= '0;
    end else if (strb.frameStart) begin
      acc    <= STEP_V;
      clkQ   <= 1'b0;
      bitIdx <= '0;
      shadow <= loadBits;
    end else if (strb.advance) begin
      if (wrap) begin
        acc  <= accSum - FRAME_V;
        clkQ <= ~clkQ;
        if (clkQ && (bitIdx != LAST_I)) bitIdx <= bitIdx + 1'b1;
      end else begin
        acc <= accSum;
      end
    end
  end

  assign serClk = clkQ;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [BITS-1:0] laneBits;
    assign laneBits   = shadow[l*BITS +: BITS];
    assign serData[l] = laneBits[LAST_I - bitIdx];
  end

  // R6
  data_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.frameStart && !clkQ) |=> $stable(bitIdx));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.advance && !strb.frameStart) |=> ($stable(clkQ) && $stable(bitIdx)));
  // R7
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.frameStart |=> $stable(shadow));
  // R2
  acc_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    acc < FRAME_V);
endmodule

// File: rtl/ohd_datapath.sv
module ohd_datapath
  import ohd_pkg::*;
#(
  parameter int FRAME_CYC  = 500,
  parameter int ORD_BITS   = 8,
  parameter int SDCC_BYTES = 3,
  parameter int LDCC_BYTES = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ohdStrb_t                strb,
  input  logic [ORD_BITS-1:0]     e1Byte,
  input  logic [ORD_BITS-1:0]     e2Byte,
  input  logic [ORD_BITS-1:0]     f1Byte,
  input  logic [SDCC_BYTES*8-1:0] sdccBytes,
  input  logic [LDCC_BYTES*8-1:0] ldccBytes,
  output logic [2:0]              ordSer,
  output logic                    ordClk,
  output logic                    sdccSer,
  output logic                    sdccClk,
  output logic                    ldccSer,
  output logic                    ldccClk
);
  localparam int SDCC_BITS = SDCC_BYTES * 8;
  localparam int LDCC_BITS = LDCC_BYTES * 8;

  // Orderwire lanes: lane 0 = E1, lane 1 = E2, lane 2 = F1
  ohd_serial_lane #(.FRAME_CYC(FRAME_CYC), .BITS(ORD_BITS), .LANES(3)) u_ordLane (
    .clk(clk), .rstN(rstN), .strb(strb),
    .loadBits({f1Byte, e2Byte, e1Byte}),
    .serClk(ordClk), .serData(ordSer)
  );

  ohd_serial_lane #(.FRAME_CYC(FRAME_CYC), .BITS(SDCC_BITS), .LANES(1)) u_sdccLane (
    .clk(clk), .rstN(rstN), .strb(strb),
    .loadBits(sdccBytes),
    .serClk(sdccClk), .serData(sdccSer)
  );

  ohd_serial_lane #(.FRAME_CYC(FRAME_CYC), .BITS(LDCC_BITS), .LANES(1)) u_ldccLane (
    .clk(clk), .rstN(rstN), .strb(strb),
    .loadBits(ldccBytes),
    .serClk(ldccClk), .serData(ldccSer)
  );
endmodule

// File: rtl/oh_serial_drop.sv
module oh_serial_drop
  import ohd_pkg::*;
#(
  parameter int FRAME_CYC  = 500,
  parameter int SDCC_BYTES = 3,
  parameter int LDCC_BYTES = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sofIn,
  input  logic [7:0]              e1Byte,
  input  logic [7:0]              e2Byte,
  input  logic [7:0]              f1Byte,
  input  logic [SDCC_BYTES*8-1:0] sdccBytes,
  input  logic [LDCC_BYTES*8-1:0] ldccBytes,
  output logic                    e1Ser,
  output logic                    e2Ser,
  output logic                    f1Ser,
  output logic                    ordClk,
  output logic                    sdccSer,
  output logic                    sdccClk,
  output logic                    ldccSer,
  output logic                    ldccClk,
  output logic                    ref8k
);
  ohdStrb_t   strb;
  logic [2:0] ordSer;

  ohd_ctrl #(.FRAME_CYC(FRAME_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .sofIn(sofIn), .strb(strb), .ref8k(ref8k)
  );

  ohd_datapath #(
    .FRAME_CYC(FRAME_CYC), .ORD_BITS(8),
    .SDCC_BYTES(SDCC_BYTES), .LDCC_BYTES(LDCC_BYTES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .e1Byte(e1Byte), .e2Byte(e2Byte), .f1Byte(f1Byte),
    .sdccBytes(sdccBytes), .ldccBytes(ldccBytes),
    .ordSer(ordSer), .ordClk(ordClk),
    .sdccSer(sdccSer), .sdccClk(sdccClk),
    .ldccSer(ldccSer), .ldccClk(ldccClk)
  );

  assign e1Ser = ordSer[0];
  assign e2Ser = ordSer[1];
  assign f1Ser = ordSer[2];
endmodule

// File: tb/oh_serial_drop_bench.sv
module oh_serial_drop_bench;
  localparam int F = 500;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sofIn = 1'b0;
  logic [7:0]  e1Byte = '0, e2Byte = '0, f1Byte = '0;
  logic [23:0] sdccBytes = '0;
  logic [71:0] ldccBytes = '0;
  logic e1Ser, e2Ser, f1Ser, ordClk, sdccSer, sdccClk, ldccSer, ldccClk, ref8k;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  string phase = "R1";

  always #4 clk = ~clk;

  oh_serial_drop #(.FRAME_CYC(F)) u_oh_serial_drop (
    .clk(clk), .rstN(rstN), .sofIn(sofIn),
    .e1Byte(e1Byte), .e2Byte(e2Byte), .f1Byte(f1Byte),
    .sdccBytes(sdccBytes), .ldccBytes(ldccBytes),
    .e1Ser(e1Ser), .e2Ser(e2Ser), .f1Ser(f1Ser), .ordClk(ordClk),
    .sdccSer(sdccSer), .sdccClk(sdccClk),
    .ldccSer(ldccSer), .ldccClk(ldccClk), .ref8k(ref8k)
  );

  // Behavioural reference model
  int mK = -1;
  int mRef = 0;
  bit mSofQ = 0;
  logic [7:0]  mE1 = '0, mE2 = '0, mF1 = '0;
  logic [23:0] mS = '0;
  logic [71:0] mL = '0;

  always @(posedge clk) begin
    if (!rstN) begin
      mK = -1; mRef = 0; mSofQ = 0;
      mE1 = '0; mE2 = '0; mF1 = '0; mS = '0; mL = '0;
    end else begin
      if (sofIn && !mSofQ) begin
        mK = 0;
        mE1 = e1Byte; mE2 = e2Byte; mF1 = f1Byte; mS = sdccBytes; mL = ldccBytes;
      end else if (mK >= 0 && mK < F - 1) begin
        mK = mK + 1;
      end
      mSofQ = sofIn;
      mRef = (mRef + 1) % F;
    end
  end

  function automatic int evCount(int bits);
    if (mK < 0) return 0;
    return (2 * bits * (mK + 1)) / F;
  endfunction

  function automatic int bitPos(int bits);
    int idx;
    idx = evCount(bits) / 2;
    if (idx > bits - 1) idx = bits - 1;
    return bits - 1 - idx;
  endfunction

  task automatic check(string req, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s (phase %s) k=%0d: actual %b expected %b", req, phase, mK, act, exp);
    end
  endtask

  // Compare every output on every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      check("R2 ordClk",  ordClk,  1'(evCount(8) & 1));
      check("R3 e1Ser",   e1Ser,   mE1[bitPos(8)]);
      check("R3 e2Ser",   e2Ser,   mE2[bitPos(8)]);
      check("R3 f1Ser",   f1Ser,   mF1[bitPos(8)]);
      check("R4 sdccClk", sdccClk, 1'(evCount(24) & 1));
      check("R6 sdccSer", sdccSer, mS[bitPos(24)]);
      check("R5 ldccClk", ldccClk, 1'(evCount(72) & 1));
      check("R6 ldccSer", ldccSer, mL[bitPos(72)]);
      check("R10 ref8k",  ref8k,   1'(!rstN || mRef < F / 2));
    end
  end

  task automatic newBytes();
    e1Byte = 8'($urandom); e2Byte = 8'($urandom); f1Byte = 8'($urandom);
    sdccBytes = 24'($urandom);
    ldccBytes = {32'($urandom), 32'($urandom), 8'($urandom)};
  endtask

  // One frame: sofIn high for 'high' cycles out of 'len'; optional mid-frame byte change
  task automatic frame(int len, int high, bit midChange);
    for (int i = 0; i < len; i++) begin
      @(posedge clk); #2;
      sofIn = (i < high);
      if (i == len - 2) newBytes();
      if (midChange && i == len / 2) newBytes();
    end
  endtask

  initial begin
    #(8 * 60000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    phase = "R1";
    repeat (5) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    check("R1 ordClk reset", ordClk, 1'b0);
    check("R1 ldccClk reset", ldccClk, 1'b0);
    check("R1 ref8k reset", ref8k, 1'b1);
    phase = "R11";
    newBytes();
    repeat (40) @(posedge clk);
    phase = "R3/R6 regular frames";
    for (int f = 0; f < 3; f++) frame(F, 56, 1'b0);
    phase = "R7 mid-frame change";
    for (int f = 0; f < 2; f++) frame(F, 56, 1'b1);
    phase = "R8 early edge";
    frame(300, 56, 1'b1);
    frame(F, 56, 1'b0);
    phase = "R8 long high";
    frame(2 * F + 50, 2 * F - 20, 1'b0);
    phase = "R9 missing pulse";
    frame(3 * F, 56, 1'b1);
    phase = "R9 resume";
    for (int f = 0; f < 2; f++) frame(F, 1, 1'b0);
    @(posedge clk);
    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule